// File: doc/BRIEF.md
# Two-Tape Turing Machine Core

This block is the datapath of a small two-tape Turing machine. It holds two parallel tapes of sixteen cells each and one head that sits over the same cell on both tapes. Each cell carries one 2-bit symbol per tape. The two symbols are packed into a 4-bit word: the upper tape uses bits [3:2] and the lower tape uses bits [1:0]. The symbol codes are 0 = circle, 1 = bar, 2 = dash and 3 = dot.

An external controller reads the symbol pair under the head from `rd_pair_o`. It answers with a new pair on `wr_pair_i`, a direction on `move_right_i` and a stop request on `halt_i`. While the machine runs, the core writes the new pair into the head cell on the falling clock edge in mid-cycle. On the next rising edge the head moves one cell, and the position wraps modulo 16. A second read port is fully independent of the head. It lets a display scan the tape at any address, and it flags the cell that lies under the head.

The sequencer has three states:
- LOAD is entered on reset. In LOAD the preload port can set cells and the head position.
- RUN steps the machine once per clock.
- HALT is entered when `halt_i` is high during RUN. Preload is allowed again in HALT.

The transitions are:
- LOAD to RUN when `start_i` is high.
- RUN to HALT when `halt_i` is high.
- HALT to RUN when `start_i` is high.

No other transitions exist.

Top module: `tm_tape_core`

## Requirements
- R1: After reset the head is at cell 0, every cell word is 0, and both `running_o` and `halted_o` are 0 (state LOAD).
- R2: In LOAD or HALT, `pl_cell_we_i` writes `pl_cell_word_i` into cell `pl_cell_addr_i`, with the upper tape in bits [3:2] and the lower tape in bits [1:0]. In the same states, `pl_head_we_i` loads `pl_head_i` into the head on the rising edge.
- R3: In RUN the preload inputs have no effect on any cell or on the head.
- R4: `rd_pair_o` always shows the word of the cell at the current head position.
- R5: In RUN with `halt_i` low, `wr_pair_i` is written into the head cell on the falling clock edge. It is visible on `rd_pair_o` before the next rising edge.
- R6: In RUN with `halt_i` low, the head moves one cell on the rising edge. It moves to the next higher address when `move_right_i` = 1 and to the next lower address when it is 0, wrapping from 15 to 0 and from 0 to 15.
- R7: `halt_i` high in RUN suppresses that cycle's write and move, and the machine enters HALT (`halted_o` = 1). It stays in HALT until `start_i` is high.
- R8: `start_i` high in LOAD or HALT enters RUN (`running_o` = 1) on the next rising edge. In RUN, `start_i` has no effect.
- R9: `scan_word_o` shows the word at `scan_addr_i` independently of the head and of writes to other cells. `scan_at_head_o` is 1 exactly when `scan_addr_i` equals the head position.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; step writes on falling edge, head moves on rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Enter RUN from LOAD or HALT |
| pl_cell_we_i | input | 1 | Preload cell write enable |
| pl_cell_addr_i | input | 4 | Preload cell address |
| pl_cell_word_i | input | 4 | Preload word (upper tape [3:2], lower tape [1:0]) |
| pl_head_we_i | input | 1 | Preload head position enable |
| pl_head_i | input | 4 | Preload head position |
| rd_pair_o | output | 4 | Symbol pair under the head |
| wr_pair_i | input | 4 | New symbol pair from the controller |
| move_right_i | input | 1 | 1 = toward higher address, 0 = toward lower |
| halt_i | input | 1 | Stop request from the controller |
| head_o | output | 4 | Current head position |
| running_o | output | 1 | Machine is in RUN |
| halted_o | output | 1 | Machine is in HALT |
| scan_addr_i | input | 4 | Display scan address |
| scan_word_o | output | 4 | Word at the scan address |
| scan_at_head_o | output | 1 | Scan address equals head position |

## Verification
The embedded properties take for granted that the controller inputs (`wr_pair_i`, `move_right_i`, `halt_i`) settle in the first half of the cycle and stay steady across the falling edge. They also take for granted that the preload inputs do not change near either clock edge. The bench drives every input shortly after a rising edge and holds it through the following falling edge, so both write and move sample settled values. Results are read after the falling edge for writes and just after the rising edge for head motion.

// File: rtl/tm_pkg.sv
package tm_pkg;
    // Symbol codes per tape (2 bits)
    typedef enum logic [1:0] {
        SYM_CIRCLE = 2'd0,
        SYM_BAR    = 2'd1,
        SYM_DASH   = 2'd2,
        SYM_DOT    = 2'd3
    } sym_e;

    // Sequencer states
    typedef enum logic [1:0] {
        ST_LOAD = 2'd0,
        ST_RUN  = 2'd1,
        ST_HALT = 2'd2
    } seq_state_e;
endpackage

// File: rtl/tm_step_fsm.sv
module tm_step_fsm
    import tm_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic start_i,
    input  logic halt_i,
    output logic step_en_o,
    output logic load_en_o,
    output logic running_o,
    output logic halted_o
);
    seq_state_e state_q, state_d;

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_LOAD: if (start_i) state_d = ST_RUN;
            ST_RUN:  if (halt_i)  state_d = ST_HALT;
            ST_HALT: if (start_i) state_d = ST_RUN;
            default: state_d = ST_LOAD;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_LOAD;
        else        state_q <= state_d;
    end

    // outputs
    always_comb begin
        step_en_o = 1'b0;
        load_en_o = 1'b0;
        running_o = 1'b0;
        halted_o  = 1'b0;
        unique case (state_q)
            ST_LOAD: load_en_o = 1'b1;
            ST_RUN: begin
                running_o = 1'b1;
                step_en_o = !halt_i;
            end
            ST_HALT: begin
                load_en_o = 1'b1;
                halted_o  = 1'b1;
            end
            default: load_en_o = 1'b1;
        endcase
    end

    // R8
    start_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!running_o && start_i) |=> running_o);

    // R7
    halt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (halted_o && !start_i) |=> halted_o);

    // R7
    halt_enter_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (running_o && halt_i) |=> (halted_o && !running_o));
endmodule

// File: rtl/tm_head_ctr.sv
module tm_head_ctr #(
    parameter int CELLS  = 16,
    localparam int ADDR_W = $clog2(CELLS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              step_en_i,
    input  logic              move_right_i,
    input  logic              load_en_i,
    input  logic              load_we_i,
    input  logic [ADDR_W-1:0] load_val_i,
    output logic [ADDR_W-1:0] head_o
);
    logic [ADDR_W-1:0] head_q, head_d;

    always_comb begin
        head_d = head_q;
        if (step_en_i)
            head_d = move_right_i ? head_q + 1'b1 : head_q - 1'b1;
        else if (load_en_i && load_we_i)
            head_d = load_val_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) head_q <= '0;
        else        head_q <= head_d;
    end

    assign head_o = head_q;

    // R3
    head_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!step_en_i && !(load_en_i && load_we_i)) |=> $stable(head_q));

    // R6
    head_right_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (step_en_i && move_right_i) |=> head_q == ADDR_W'($past(head_q) + 1));

    // R6
    head_left_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (step_en_i && !move_right_i) |=> head_q == ADDR_W'($past(head_q) - 1));
endmodule

// File: rtl/tm_tape_ram.sv
module tm_tape_ram #(
    parameter int CELLS  = 16,
    parameter int WORD_W = 4,
    localparam int ADDR_W = $clog2(CELLS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we_i,
    input  logic [ADDR_W-1:0] waddr_i,
    input  logic [WORD_W-1:0] wdata_i,
    input  logic [ADDR_W-1:0] raddr_a_i,
    output logic [WORD_W-1:0] rdata_a_o,
    input  logic [ADDR_W-1:0] raddr_b_i,
    output logic [WORD_W-1:0] rdata_b_o
);
    logic [WORD_W-1:0] mem_q [CELLS];

    // write port: mid-cycle, falling edge
    always_ff @(negedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < CELLS; i++) mem_q[i] <= '0;
        end else if (we_i) begin
            mem_q[waddr_i] <= wdata_i;
        end
    end

    // two independent read ports
    assign rdata_a_o = mem_q[raddr_a_i];
    assign rdata_b_o = mem_q[raddr_b_i];

    // R5
    wr_land_chk: assert property (@(negedge clk) disable iff (!rst_n)
        we_i |=> mem_q[$past(waddr_i)] == $past(wdata_i));

    // R3
    wr_quiet_chk: assert property (@(negedge clk) disable iff (!rst_n)
        !we_i |=> mem_q[$past(raddr_b_i)] == $past(rdata_b_o));
endmodule

// File: rtl/tm_tape_core.sv
module tm_tape_core
    import tm_pkg::*;
#(
    parameter int CELLS  = 16,
    parameter int SYM_W  = 2,
    localparam int ADDR_W = $clog2(CELLS),
    localparam int WORD_W = 2 * SYM_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic              pl_cell_we_i,
    input  logic [ADDR_W-1:0] pl_cell_addr_i,
    input  logic [WORD_W-1:0] pl_cell_word_i,
    input  logic              pl_head_we_i,
    input  logic [ADDR_W-1:0] pl_head_i,
    output logic [WORD_W-1:0] rd_pair_o,
    input  logic [WORD_W-1:0] wr_pair_i,
    input  logic              move_right_i,
    input  logic              halt_i,
    output logic [ADDR_W-1:0] head_o,
    output logic              running_o,
    output logic              halted_o,
    input  logic [ADDR_W-1:0] scan_addr_i,
    output logic [WORD_W-1:0] scan_word_o,
    output logic              scan_at_head_o
);
    logic              step_en, load_en;
    logic              ram_we;
    logic [ADDR_W-1:0] ram_waddr;
    logic [WORD_W-1:0] ram_wdata;

    tm_step_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .start_i   (start_i),
        .halt_i    (halt_i),
        .step_en_o (step_en),
        .load_en_o (load_en),
        .running_o (running_o),
        .halted_o  (halted_o)
    );

    tm_head_ctr #(.CELLS(CELLS)) u_head (
        .clk          (clk),
        .rst_n        (rst_n),
        .step_en_i    (step_en),
        .move_right_i (move_right_i),
        .load_en_i    (load_en),
        .load_we_i    (pl_head_we_i),
        .load_val_i   (pl_head_i),
        .head_o       (head_o)
    );

    // write arbitration: step write in RUN, preload otherwise
    always_comb begin
        ram_we    = 1'b0;
        ram_waddr = pl_cell_addr_i;
        ram_wdata = pl_cell_word_i;
        if (step_en) begin
            ram_we    = 1'b1;
            ram_waddr = head_o;
            ram_wdata = wr_pair_i;
        end else if (load_en && pl_cell_we_i) begin
            ram_we    = 1'b1;
        end
    end

    tm_tape_ram #(.CELLS(CELLS), .WORD_W(WORD_W)) u_ram (
        .clk       (clk),
        .rst_n     (rst_n),
        .we_i      (ram_we),
        .waddr_i   (ram_waddr),
        .wdata_i   (ram_wdata),
        .raddr_a_i (head_o),
        .rdata_a_o (rd_pair_o),
        .raddr_b_i (scan_addr_i),
        .rdata_b_o (scan_word_o)
    );

    assign scan_at_head_o = (scan_addr_i == head_o);

    // R7
    halt_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (running_o && halt_i) |=> (halted_o && $stable(head_o)));

    // R3
    run_no_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (running_o && halt_i && pl_head_we_i) |=> $stable(head_o));

    // R2
    head_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!running_o && pl_head_we_i) |=> head_o == $past(pl_head_i));
endmodule

// File: tb/tm_tape_core_tb_top.sv
module tm_tape_core_tb_top;
    logic       clk = 0;
    logic       rst_n = 0;
    logic       start_i = 0;
    logic       pl_cell_we_i = 0;
    logic [3:0] pl_cell_addr_i = 0;
    logic [3:0] pl_cell_word_i = 0;
    logic       pl_head_we_i = 0;
    logic [3:0] pl_head_i = 0;
    logic [3:0] rd_pair_o;
    logic [3:0] wr_pair_i = 0;
    logic       move_right_i = 0;
    logic       halt_i = 0;
    logic [3:0] head_o;
    logic       running_o, halted_o;
    logic [3:0] scan_addr_i = 0;
    logic [3:0] scan_word_o;
    logic       scan_at_head_o;

    int checks = 0;
    int errors = 0;
    bit done = 0;
    logic [3:0] model [16];
    logic [3:0] mhead;

    always #5 clk = ~clk;

    tm_tape_core dut_i (.*);

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    // inputs change at posedge+1
    task automatic sync();
        @(posedge clk); #1;
    endtask

    task automatic preload(input logic [3:0] a, input logic [3:0] w);
        pl_cell_we_i = 1; pl_cell_addr_i = a; pl_cell_word_i = w;
        sync();
        pl_cell_we_i = 0;
        model[a] = w;
    endtask

    task automatic load_head(input logic [3:0] h);
        pl_head_we_i = 1; pl_head_i = h;
        sync();
        pl_head_we_i = 0;
        mhead = h;
    endtask

    task automatic do_start();
        start_i = 1;
        sync();
        start_i = 0;
        chk("R8 running after start", running_o, 1);
    endtask

    // one running step: write at negedge, move at posedge
    task automatic step(input logic [3:0] wp, input logic dir, input logic hlt);
        wr_pair_i = wp; move_right_i = dir; halt_i = hlt;
        @(negedge clk); #1;
        if (!hlt) begin
            chk("R5 mid-cycle write", rd_pair_o, wp);
            model[mhead] = wp;
        end else begin
            chk("R7 no write on halt", rd_pair_o, model[mhead]);
        end
        @(posedge clk); #1;
        halt_i = 0;
        if (!hlt) mhead = dir ? mhead + 4'd1 : mhead - 4'd1;
        chk("R6 head position", head_o, mhead);
        if (hlt) chk("R7 halted", halted_o, 1);
    endtask

    task automatic t_reset();
        chk("R1 head zero", head_o, 0);
        chk("R1 not running", running_o, 0);
        chk("R1 not halted", halted_o, 0);
        for (int i = 0; i < 16; i++) begin
            scan_addr_i = 4'(i); #1;
            chk("R1 cell clear", scan_word_o, 0);
            model[i] = 0;
        end
        mhead = 0;
    endtask

    task automatic t_preload();
        preload(4'd3, 4'hB);
        preload(4'd9, 4'h6);
        load_head(4'd9);
        chk("R2 head loaded", head_o, 9);
        chk("R4 read under head", rd_pair_o, 4'h6);
        scan_addr_i = 3; #1;
        chk("R2 cell word", scan_word_o, 4'hB);
        chk("R9 scan_at_head off", scan_at_head_o, 0);
        scan_addr_i = 9; #1;
        chk("R9 scan_at_head on", scan_at_head_o, 1);
    endtask

    task automatic t_run_basic();
        do_start();
        scan_addr_i = 3;
        // preload attempts while running must be ignored (R3)
        pl_cell_we_i = 1; pl_cell_addr_i = 4'd3; pl_cell_word_i = 4'h0;
        pl_head_we_i = 1; pl_head_i = 4'd0;
        start_i = 1;
        step(4'h5, 1'b1, 1'b0);
        pl_cell_we_i = 0; pl_head_we_i = 0; start_i = 0;
        chk("R3 cell untouched in run", scan_word_o, 4'hB);
        chk("R8 start ignored in run", running_o, 1);
        step(4'hA, 1'b0, 1'b0);
        step(4'hF, 1'b0, 1'b0);
        scan_addr_i = 9; #1;
        chk("R9 scan independent", scan_word_o, model[9]);
        step(4'h2, 1'b1, 1'b1);
        sync(); sync();
        chk("R7 stays halted", halted_o, 1);
        chk("R7 head frozen", head_o, mhead);
    endtask

    task automatic t_wrap();
        load_head(4'd15);
        chk("R2 head load in halt", head_o, 15);
        preload(4'd0, 4'h3);
        do_start();
        step(4'h1, 1'b1, 1'b0);
        chk("R6 wrap 15 to 0", head_o, 0);
        chk("R4 read after wrap", rd_pair_o, 4'h3);
        step(4'h2, 1'b0, 1'b0);
        chk("R6 wrap 0 to 15", head_o, 15);
        step(4'h0, 1'b0, 1'b1);
    endtask

    // binary increment on lower tape, upper tape kept
    task automatic t_increment();
        logic fin;
        preload(4'd3, 4'hE);  // upper dot, lower dash (frame)
        preload(4'd4, 4'h4);  // upper bar, lower 0
        preload(4'd5, 4'h1);  // lower 1
        preload(4'd6, 4'h9);  // upper dash, lower 1
        preload(4'd7, 4'h3);  // lower dot (frame)
        load_head(4'd6);
        do_start();
        fin = 0;
        for (int n = 0; n < 10 && running_o; n++) begin
            logic [1:0] lo;
            lo = rd_pair_o[1:0];
            if (fin || lo > 2'd1) step(rd_pair_o, 1'b1, 1'b1);
            else if (lo == 2'd1) step({rd_pair_o[3:2], 2'd0}, 1'b0, 1'b0);
            else begin
                step({rd_pair_o[3:2], 2'd1}, 1'b1, 1'b0);
                fin = 1;
            end
        end
        chk("R7 increment halted", halted_o, 1);
        chk("R6 increment end head", head_o, 5);
        scan_addr_i = 4; #1; chk("R5 bit2", scan_word_o, 4'h5);
        scan_addr_i = 5; #1; chk("R5 bit1", scan_word_o, 4'h0);
        scan_addr_i = 6; #1; chk("R5 bit0 upper kept", scan_word_o, 4'h8);
        scan_addr_i = 3; #1; chk("R9 frame kept", scan_word_o, 4'hE);
    endtask

    initial begin
        #1;
        repeat (3) @(posedge clk);
        #2 rst_n = 1;
        #1;
        t_reset();
        sync();
        t_preload();
        t_run_basic();
        t_wrap();
        t_increment();
        finish_run();
    end

    initial begin
        #2_000_000;
        checks++; errors++;
        $display("FAIL watchdog expired");
        finish_run();
    end
endmodule